// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32 by 32 two-colour pointer over a stream of palette-indexed pixels. Each pixel arrives with its column and row. The block decides whether the pointer covers that pixel. If it does, the pixel is replaced by one of two reserved palette entries. If not, the pixel's own index passes through, widened to nine bits so that the reserved entries can be encoded.

Software controls the pointer through a small word-addressed register window. One word packs the pointer's column and row. A 32-entry shape plane selects which pointer pixels are drawn. A 32-entry colour plane picks one of the two pointer colours for each drawn pixel. A general-purpose control word reads back with a fixed presence flag set. The pointer is hidden by moving it to a position far beyond the visible area. Its right edge is clipped at the active line width, which is supplied as an input.

Top module: `ovl_top`

## Requirements
- R1: After reset, out_valid is 0, reg_rdata is 0 and the pointer sits at column 0xF000, row 0xF000, so no pixel with smaller coordinates is overlaid.
- R2: A write to byte offset 0x8FC sets the pointer column from wdata[31:16] and the pointer row from wdata[15:0].
- R3: A write to offset 0x900 + 4*r (r = 0..31) stores shape row r. A write to offset 0x980 + 4*r stores colour row r.
- R4: Only pixel rows from the pointer row through the pointer row + 31 can be overlaid.
- R5: Pixels are overlaid only when the pointer column is less than line_width. The covered columns run from the pointer column up to, but not including, the smaller of (pointer column + 32) and line_width.
- R6: The pixel at column offset c inside the pointer uses bit 31-c of its shape row and bit 31-c of its colour row.
- R7: For a covered pixel whose shape bit is 1, out_idx is 259 when the colour bit is 1 and 258 when it is 0.
- R8: For a pixel that is not covered, or whose shape bit is 0, out_idx is {1'b0, pix_idx}.
- R9: Each pixel's result appears exactly one clock after it is presented, and out_valid is high in that cycle only when pix_valid was high.
- R10: A read of offset 0x818 returns the last value written there, with bit 25 forced to 1, on reg_rdata one clock after reg_rd.
- R11: A read of any other offset returns 0.
- R12: Writes to offsets outside 0x818, 0x8FC and 0x900..0x9FF change neither the overlay nor the read-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after reg_rd |
| line_width | input | 16 | Active pixels per line, used for clipping |
| pix_valid | input | 1 | Incoming pixel qualifier |
| pix_x | input | 16 | Incoming pixel column |
| pix_y | input | 16 | Incoming pixel row |
| pix_idx | input | 8 | Incoming palette index |
| out_valid | output | 1 | Outgoing pixel qualifier |
| out_idx | output | 9 | Outgoing palette entry number |

## Verification
The shape and colour planes are loaded with rotating patterns, so that every row has a different mix of ones and zeros. A rectangle two pixels wider than the pointer on each side is then swept. This separates the pass-through, the shape-0 pass-through and both pointer colours. It also exposes any off-by-one at the four edges and any reversal of bit order. Further sweeps place the pointer so that line_width cuts it part way, and then exactly at line_width, to separate partial clipping from full suppression. Parked-at-reset sweeps, reads of the control word and stray writes show that the pointer stays hidden and that unmapped offsets have no effect.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CUR_DIM   = 32;
  localparam int CUR_IDX_W = $clog2(CUR_DIM);
  localparam int REG_AW    = 12;
  localparam int REG_DW    = 32;

  localparam logic [REG_AW-1:0] OFS_MISC  = 12'h818;
  localparam logic [REG_AW-1:0] OFS_POS   = 12'h8FC;
  localparam logic [REG_AW-1:0] OFS_SHAPE = 12'h900;
  localparam logic [REG_AW-1:0] OFS_COLOR = 12'h980;
  localparam int                MISC_FLAG_BIT = 25;

  localparam logic [15:0] PARK_COORD = 16'hF000;
  localparam logic [8:0]  ENTRY_CLR  = 9'd258;
  localparam logic [8:0]  ENTRY_SET  = 9'd259;

  typedef struct packed {
    logic                 hit;
    logic [CUR_IDX_W-1:0] row;
    logic [CUR_IDX_W-1:0] bit_sel;
  } win_t;
endpackage

// File: rtl/ovl_plane.sv
module ovl_plane #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile
  import ovl_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  output logic [COORD_W-1:0]   pos_x,
  output logic [COORD_W-1:0]   pos_y,
  output logic                 shape_we,
  output logic                 color_we,
  output logic [CUR_IDX_W-1:0] plane_row
);
  localparam int SPAN_LSB = CUR_IDX_W + 2;

  logic [REG_DW-1:0] misc_q;

  assign plane_row = reg_addr[SPAN_LSB-1:2];
  assign shape_we  = reg_wr && (reg_addr[REG_AW-1:SPAN_LSB] == OFS_SHAPE[REG_AW-1:SPAN_LSB]);
  assign color_we  = reg_wr && (reg_addr[REG_AW-1:SPAN_LSB] == OFS_COLOR[REG_AW-1:SPAN_LSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x  <= COORD_W'(PARK_COORD);
      pos_y  <= COORD_W'(PARK_COORD);
      misc_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_POS) begin
        pos_x <= reg_wdata[31:16];
        pos_y <= reg_wdata[15:0];
      end
      if (reg_addr == OFS_MISC) misc_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd && reg_addr == OFS_MISC) begin
      reg_rdata <= misc_q | (REG_DW'(1) << MISC_FLAG_BIT);
    end else begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/ovl_window.sv
module ovl_window
  import ovl_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [COORD_W-1:0] line_width,
  output win_t               win
);
  localparam int EW = COORD_W + 1;

  logic [EW-1:0] xe, ye, px, py, wd, dx, dy;
  logic          in_rows, in_cols, visible;

  assign xe = {1'b0, pix_x};
  assign ye = {1'b0, pix_y};
  assign px = {1'b0, pos_x};
  assign py = {1'b0, pos_y};
  assign wd = {1'b0, line_width};
  assign dx = xe - px;
  assign dy = ye - py;

  assign in_rows = (ye >= py) && (ye < py + EW'(CUR_DIM));
  assign in_cols = (xe >= px) && (xe < px + EW'(CUR_DIM));
  assign visible = (px < wd) && (xe < wd);

  assign win.hit     = in_rows && in_cols && visible;
  assign win.row     = dy[CUR_IDX_W-1:0];
  assign win.bit_sel = CUR_IDX_W'(CUR_DIM - 1) - dx[CUR_IDX_W-1:0];
endmodule

// File: rtl/ovl_top.sv
module ovl_top
  import ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [COORD_W-1:0] line_width,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [PIX_W-1:0]   pix_idx,
  output logic               out_valid,
  output logic [8:0]         out_idx
);
  localparam int OUT_W = 9;

  logic [COORD_W-1:0]   pos_x, pos_y;
  logic                 shape_we, color_we;
  logic [CUR_IDX_W-1:0] plane_row;
  logic [CUR_DIM-1:0]   shape_row, color_row;
  win_t                 win;
  logic [OUT_W-1:0]     next_idx;

  ovl_regfile #(.COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pos_x(pos_x), .pos_y(pos_y), .shape_we(shape_we),
    .color_we(color_we), .plane_row(plane_row)
  );

  ovl_plane #(.ROWS(CUR_DIM), .WIDTH(CUR_DIM)) u_shape (
    .clk(clk), .we(shape_we), .waddr(plane_row), .wdata(reg_wdata),
    .raddr(win.row), .rdata(shape_row)
  );

  ovl_plane #(.ROWS(CUR_DIM), .WIDTH(CUR_DIM)) u_color (
    .clk(clk), .we(color_we), .waddr(plane_row), .wdata(reg_wdata),
    .raddr(win.row), .rdata(color_row)
  );

  ovl_window #(.COORD_W(COORD_W)) u_win (
    .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
    .line_width(line_width), .win(win)
  );

  always_comb begin
    next_idx = OUT_W'(pix_idx);
    if (win.hit && shape_row[win.bit_sel]) begin
      next_idx = color_row[win.bit_sel] ? ENTRY_SET : ENTRY_CLR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_idx <= next_idx;
    end
  end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rd,
  input logic [11:0]        reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [COORD_W-1:0] line_width,
  input logic               pix_valid,
  input logic [COORD_W-1:0] pix_x,
  input logic [PIX_W-1:0]   pix_idx,
  input logic               out_valid,
  input logic [8:0]         out_idx
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid); // R9
  AST_CURSOR_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx[8]) |-> (out_idx[8:1] == 8'h81)); // R7
  AST_CLIP_PASS: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_x >= line_width) |=> (out_idx == {1'b0, $past(pix_idx)})); // R5
  AST_MISC_FLAG: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 12'h818) |=> reg_rdata[25]); // R10
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != 12'h818) |=> (reg_rdata == 32'd0)); // R11
endmodule

bind ovl_top ovl_checker #(.COORD_W(COORD_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .line_width(line_width), .pix_valid(pix_valid),
  .pix_x(pix_x), .pix_idx(pix_idx), .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/sim_ovl_top.sv
`timescale 1ns/1ps
module sim_ovl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] line_width = 16'd64;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [7:0]  pix_idx = '0;
  logic        out_valid;
  logic [8:0]  out_idx;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_x = 16'hF000, cur_y = 16'hF000, cur_w = 64;
  logic [31:0] m_shape [32];
  logic [31:0] m_color [32];

  always #2.5 clk = ~clk;

  ovl_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_width(line_width), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_idx(pix_idx), .out_valid(out_valid), .out_idx(out_idx)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  function automatic logic [8:0] model(input int x, input int y, input logic [7:0] p);
    int r, c;
    if (y >= cur_y && y < cur_y + 32 && cur_x < cur_w &&
        x >= cur_x && x < cur_x + 32 && x < cur_w) begin
      r = y - cur_y;
      c = x - cur_x;
      if (m_shape[r][31-c]) return m_color[r][31-c] ? 9'd259 : 9'd258;
    end
    return {1'b0, p};
  endfunction

  task automatic pixel(input string req, input int x, input int y);
    logic [7:0] p;
    p = 8'((x * 7) ^ (y * 13) ^ 8'h5A);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_idx = p;
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {23'd0, out_idx}, {23'd0, model(x, y, p)});
  endtask

  task automatic sweep(input string req, input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) pixel(req, x, y);
  endtask

  task automatic set_pos(input int x, input int y);
    wr(12'h8FC, {16'(x), 16'(y)});
    cur_x = x; cur_y = y;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    for (int r = 0; r < 32; r++) begin m_shape[r] = '1; m_color[r] = '0; end
    sweep("R1 parked", 0, 3, 0, 3);
    pixel("R1 parked far", 16'hEFFF, 16'hEFFF);
    // R9 idle cycle
    @(negedge clk);
    check("R9 idle", {31'd0, out_valid}, 32'd0);
    // R10 / R11 register reads
    rd(12'h818, d); check("R10 misc reset", d, 32'h0200_0000);
    wr(12'h818, 32'h00A5_00C3);
    rd(12'h818, d); check("R10 misc flag", d, 32'h02A5_00C3);
    rd(12'h8FC, d); check("R11 pos read", d, 32'd0);
    rd(12'h904, d); check("R11 shape read", d, 32'd0);
    rd(12'h000, d); check("R11 other read", d, 32'd0);
    // R3 load planes with rotating patterns
    for (int r = 0; r < 32; r++) begin
      m_shape[r] = (32'hA5C3_96F0 << r) | (r == 0 ? 32'd0 : (32'hA5C3_96F0 >> (32 - r)));
      m_color[r] = 32'h3C5A_F00F ^ (32'(r) * 32'h0110_0101);
      wr(12'(12'h900 + 4 * r), m_shape[r]);
      wr(12'(12'h980 + 4 * r), m_color[r]);
    end
    // R2 R4 R6 R7 R8 full window
    cur_w = 64; line_width = 16'd64;
    set_pos(10, 6);
    sweep("R4 R6 R7 R8 window", 8, 44, 4, 40);
    set_pos(3, 2);
    sweep("R2 packing", 2, 5, 1, 3);
    // R5 partial clip
    cur_w = 40; line_width = 16'd40;
    set_pos(20, 0);
    sweep("R5 partial clip", 18, 41, 0, 33);
    // R5 pointer at line width
    set_pos(40, 4);
    sweep("R5 at width", 36, 44, 4, 6);
    // R12 stray writes
    cur_w = 64; line_width = 16'd64;
    set_pos(10, 6);
    wr(12'hA00, 32'h0000_0000);
    wr(12'h8F8, 32'h0000_0000);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h81C, 32'h0);
    rd(12'h818, d); check("R12 misc kept", d, 32'h02A5_00C3);
    sweep("R12 overlay kept", 8, 44, 5, 8);
    sweep("R12 overlay kept", 8, 44, 36, 38);
    summary();
  end
endmodule